// File: doc/BRIEF.md
# Four-Quadrant Switch Steering Logic

This block sits between the pulse-width modulator and the gate drivers of a bidirectional flyback converter that produces a ringing voltage. The converter has three switches: a primary switch, an n-channel secondary switch and a p-channel secondary switch. Power can flow toward the output or back toward the input, and the reference can be positive or negative. The block turns these conditions into one of four operating modes. For each gate it then selects the modulated pulse, the synchronous-rectifier phase, or off.

The mode depends on two sign bits. One is the polarity of the reference. The other is the sign of the error, which is set when the output has overtaken the reference. The mode is captured only at the start of a switching cycle, so a pulse already in progress is never cut short by a change of steering. A cycle-by-cycle current-limit flag suppresses the switch that is being modulated. An enable input turns every switch off. The p-channel gate is driven with inverted polarity, so it idles high.

Top module: `rs_steer_top`

## Requirements
- R1: The mode latched at a cycle start is decoded from {ref_neg, err_over} as follows: 00 gives mode 1 (positive reference, forward flow), 01 gives mode 2 (positive reference, reverse flow), 11 gives mode 3 (negative reference, forward flow), and 10 gives mode 4 (negative reference, reverse flow).
- R2: ref_neg and err_over are sampled only in a clock where cyc_start is 1. A change at any other time has no effect until the next cycle start.
- R3: pri_g follows the modulated pulse in modes 1 and 3 and is 0 in modes 2 and 4.
- R4: nsec_g follows the modulated pulse in mode 2, acts as the rectifier in mode 3, and is 0 in modes 1 and 4.
- R5: psec_gn is active low. It is driven low by the modulated pulse in mode 4 and by the rectifier phase in mode 1, and is high in modes 2 and 3.
- R6: A switch acting as rectifier is on exactly when rect_ph is 1 and pwm_in is 0, so it turns on once the pulse has ended and stays on for the rest of the cycle.
- R7: When ilim is 1, the switch being modulated is held off from that clock until the next cycle start. The rectifier switch is not affected.
- R8: When en is 0, pri_g and nsec_g are 0 and psec_gn is 1 from the next clock onward.
- R9: During reset and after it, pri_g and nsec_g are 0 and psec_gn is 1 until a cycle start has latched a mode.
- R10: Each gate output is registered, so it reflects the inputs sampled at the clock edge that precedes it.
- R11: No two of the three switches are on at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Output enable; 0 turns all switches off |
| cyc_start | input | 1 | One-clock marker of the start of a switching cycle |
| ref_neg | input | 1 | 1 when the reference is negative |
| err_over | input | 1 | 1 when the output exceeds the reference |
| pwm_in | input | 1 | Modulated pulse train |
| rect_ph | input | 1 | Rectifier phase of the switching cycle |
| ilim | input | 1 | Current-limit flag |
| pri_g | output | 1 | Primary switch gate, active high |
| nsec_g | output | 1 | n-channel secondary gate, active high |
| psec_gn | output | 1 | p-channel secondary gate, active low |

## Verification
The hardest situation to reach from the ports is a current-limit hit that falls inside a cycle. The flag is raised for a single clock together with a pulse and then dropped while the pulse continues. That tests whether the block still holds the switch off after the flag has gone away, and whether the rectifier phase later in the same cycle still conducts. The stimulus then starts a fresh cycle to show that the hold is released. A second awkward case is a change of the sign bits in the middle of a cycle, which is driven between two cycle starts to show that steering waits for the next start.

// File: rtl/rs_pkg.sv
package rs_pkg;
  // Mode code is {reference negative, output above reference}
  typedef enum logic [1:0] {
    MD_FWD_POS = 2'b00,  // mode 1
    MD_REV_POS = 2'b01,  // mode 2
    MD_REV_NEG = 2'b10,  // mode 4
    MD_FWD_NEG = 2'b11   // mode 3
  } mode_e;

  localparam int MODE_W = $bits(mode_e);

  function automatic mode_e decode_mode(input logic ref_neg, input logic err_over);
    return mode_e'({ref_neg, err_over});
  endfunction
endpackage

// File: rtl/rs_mode_latch.sv
module rs_mode_latch
  import rs_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cyc_start,
  input  logic   ref_neg,
  input  logic   err_over,
  output mode_e  mode_q,
  output logic   vld_q
);
  mode_e mode_d;
  logic  vld_d;

  always_comb begin
    mode_d = mode_q;
    vld_d  = vld_q;
    if (cyc_start) begin
      mode_d = decode_mode(ref_neg, err_over);
      vld_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MD_FWD_POS;
      vld_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      vld_q  <= vld_d;
    end
  end
endmodule

// File: rtl/rs_limit_hold.sv
module rs_limit_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_start,
  input  logic ilim,
  output logic blk
);
  logic hold_q, hold_d;

  // cleared at each cycle start, set by any limit hit within the cycle
  always_comb hold_d = (cyc_start ? 1'b0 : hold_q) | ilim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_d;
  end

  assign blk = hold_q | ilim;
endmodule

// File: rtl/rs_gate_mux.sv
module rs_gate_mux
  import rs_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  logic  vld,
  input  mode_e mode,
  input  logic  pwm_in,
  input  logic  rect_ph,
  input  logic  blk,
  output logic  pri_q,
  output logic  nsec_q,
  output logic  psec_q
);
  logic pw, rect, live;
  logic pri_d, nsec_d, psec_d;

  always_comb begin
    pw     = pwm_in & ~blk;
    rect   = rect_ph & ~pwm_in;
    live   = en & vld;
    pri_d  = 1'b0;
    nsec_d = 1'b0;
    psec_d = 1'b0;
    unique case (mode)
      MD_FWD_POS: begin pri_d = pw;  psec_d = rect; end
      MD_REV_POS: begin nsec_d = pw; end
      MD_FWD_NEG: begin pri_d = pw;  nsec_d = rect; end
      MD_REV_NEG: begin psec_d = pw; end
      default:    ;
    endcase
    pri_d  = pri_d  & live;
    nsec_d = nsec_d & live;
    psec_d = psec_d & live;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_q  <= 1'b0;
      nsec_q <= 1'b0;
      psec_q <= 1'b0;
    end else begin
      pri_q  <= pri_d;
      nsec_q <= nsec_d;
      psec_q <= psec_d;
    end
  end
endmodule

// File: rtl/rs_steer_top.sv
module rs_steer_top
  import rs_pkg::*;
#(
  parameter bit PSEC_INV = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic cyc_start,
  input  logic ref_neg,
  input  logic err_over,
  input  logic pwm_in,
  input  logic rect_ph,
  input  logic ilim,
  output logic pri_g,
  output logic nsec_g,
  output logic psec_gn
);
  mode_e mode_w;
  logic  vld_w, blk_w, psec_act;

  rs_mode_latch i_mode (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start),
    .ref_neg(ref_neg), .err_over(err_over),
    .mode_q(mode_w), .vld_q(vld_w)
  );

  rs_limit_hold i_lim (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start),
    .ilim(ilim), .blk(blk_w)
  );

  rs_gate_mux i_mux (
    .clk(clk), .rst_n(rst_n), .en(en), .vld(vld_w), .mode(mode_w),
    .pwm_in(pwm_in), .rect_ph(rect_ph), .blk(blk_w),
    .pri_q(pri_g), .nsec_q(nsec_g), .psec_q(psec_act)
  );

  generate
    if (PSEC_INV) begin : g_pch_inv
      assign psec_gn = ~psec_act;
    end else begin : g_pch_true
      assign psec_gn = psec_act;
    end
  endgenerate
endmodule

// File: rtl/rs_steer_chk.sv
module rs_steer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       cyc_start,
  input logic       pwm_in,
  input logic       ilim,
  input logic [1:0] mode,
  input logic       pri_g,
  input logic       nsec_g,
  input logic       psec_gn
);
  a_r2_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_start |=> $stable(mode));

  a_r3_pri_needs_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pri_g |-> $past(pwm_in));

  a_r7_limit_pri: assert property (@(posedge clk) disable iff (!rst_n)
    ilim |=> !pri_g);

  a_r7_limit_nsec: assert property (@(posedge clk) disable iff (!rst_n)
    (ilim && mode == 2'b01) |=> !nsec_g);

  a_r7_limit_psec: assert property (@(posedge clk) disable iff (!rst_n)
    (ilim && mode == 2'b10) |=> psec_gn);

  a_r8_disable_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!pri_g && !nsec_g && psec_gn));

  a_r11_one_switch: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({pri_g, nsec_g, !psec_gn}) <= 1);
endmodule

bind rs_steer_top rs_steer_chk i_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .cyc_start(cyc_start),
  .pwm_in(pwm_in), .ilim(ilim), .mode(mode_w),
  .pri_g(pri_g), .nsec_g(nsec_g), .psec_gn(psec_gn)
);

// File: tb/test_rs_steer_top.sv
`timescale 1ns/1ps
module test_rs_steer_top;
  logic clk = 1'b0;
  logic rst_n, en, cyc_start, ref_neg, err_over, pwm_in, rect_ph, ilim;
  logic pri_g, nsec_g, psec_gn;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rs_steer_top i_rs_steer_top (
    .clk(clk), .rst_n(rst_n), .en(en), .cyc_start(cyc_start),
    .ref_neg(ref_neg), .err_over(err_over), .pwm_in(pwm_in),
    .rect_ph(rect_ph), .ilim(ilim),
    .pri_g(pri_g), .nsec_g(nsec_g), .psec_gn(psec_gn)
  );

  // exp = {primary on, n-channel on, p-channel on}; p-channel pin is active low
  task automatic chk(input logic [2:0] exp, input string tag);
    logic [2:0] act;
    act = {pri_g, nsec_g, ~psec_gn};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: gates(pri,nsec,psec_on)=%b expected %b", tag, act, exp);
    end
    checks++;
    if ($countones(act) > 1) begin
      errors++;
      $display("FAIL R11 during %s: gates=%b expected at most one on", tag, act);
    end
  endtask

  task automatic step(input logic cs, input logic rn, input logic eo,
                      input logic pw, input logic rp, input logic il);
    @(negedge clk);
    cyc_start = cs; ref_neg = rn; err_over = eo;
    pwm_in = pw; rect_ph = rp; ilim = il;
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; en = 1'b1; cyc_start = 0; ref_neg = 0; err_over = 0;
    pwm_in = 0; rect_ph = 0; ilim = 0;
    repeat (3) @(posedge clk);
    #1 chk(3'b000, "R9 in reset");
    @(negedge clk) rst_n = 1'b1;
    step(0, 0, 0, 1, 0, 0); chk(3'b000, "R9 no mode yet, pulse");
    step(0, 0, 0, 0, 1, 0); chk(3'b000, "R9 no mode yet, rect");
  endtask

  task automatic t_mode(input logic rn, input logic eo,
                        input logic [2:0] e_pw, input logic [2:0] e_rc, input string tag);
    step(1, rn, eo, 0, 0, 0); chk(3'b000, {tag, " cycle start"});
    step(0, rn, eo, 1, 0, 0); chk(e_pw, {tag, " pulse"});
    step(0, rn, eo, 0, 1, 0); chk(e_rc, {tag, " rectifier R6"});
    step(0, rn, eo, 1, 1, 0); chk(e_pw, {tag, " pulse wins over rect_ph R6"});
    step(0, rn, eo, 0, 0, 0); chk(3'b000, {tag, " idle"});
  endtask

  task automatic t_defer();
    step(1, 0, 0, 0, 0, 0);
    step(0, 0, 1, 1, 0, 0); chk(3'b100, "R2 mid-cycle sign change ignored");
    step(0, 1, 0, 1, 0, 0); chk(3'b100, "R2 mid-cycle polarity change ignored");
    step(1, 0, 1, 0, 0, 0);
    step(0, 0, 1, 1, 0, 0); chk(3'b010, "R2 new mode at next start");
  endtask

  task automatic t_limit();
    step(1, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 1); chk(3'b000, "R7 limit blocks primary");
    step(0, 0, 0, 1, 0, 0); chk(3'b000, "R7 block held after flag drops");
    step(0, 0, 0, 0, 1, 0); chk(3'b001, "R7 rectifier unaffected");
    step(1, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0); chk(3'b100, "R7 released at cycle start");
    step(1, 1, 0, 0, 0, 0);
    step(0, 1, 0, 1, 0, 1); chk(3'b000, "R7 limit blocks p-channel pulse");
    step(1, 0, 1, 0, 0, 0);
    step(0, 0, 1, 1, 0, 1); chk(3'b000, "R7 limit blocks n-channel pulse");
  endtask

  task automatic t_enable();
    step(1, 0, 0, 0, 0, 0);
    @(negedge clk) en = 1'b0;
    step(0, 0, 0, 1, 0, 0); chk(3'b000, "R8 disabled pulse");
    step(0, 0, 0, 0, 1, 0); chk(3'b000, "R8 disabled rect, pin high");
    @(negedge clk) en = 1'b1;
    step(0, 0, 0, 1, 0, 0); chk(3'b100, "R8 re-enabled");
  endtask

  task automatic t_latency();
    step(1, 0, 0, 0, 0, 0);
    @(negedge clk) pwm_in = 1'b1;
    #1;
    checks++;
    if (pri_g !== 1'b0) begin
      errors++; $display("FAIL R10 before edge: pri_g=%b expected 0", pri_g);
    end
    @(posedge clk); #1;
    checks++;
    if (pri_g !== 1'b1) begin
      errors++; $display("FAIL R10 after edge: pri_g=%b expected 1", pri_g);
    end
    step(0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_mode(0, 0, 3'b100, 3'b001, "R1 R3 R5 mode1");
    t_mode(0, 1, 3'b010, 3'b000, "R1 R4 mode2");
    t_mode(1, 1, 3'b100, 3'b010, "R1 R3 R4 mode3");
    t_mode(1, 0, 3'b001, 3'b000, "R1 R5 mode4");
    t_defer();
    t_limit();
    t_enable();
    t_latency();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule